// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Write-Once Divider

This block holds a 16-bit counter that runs freely from the block clock through a selectable prescaler. It also holds one 8-bit control register, reached through a small select/write port. The register has four interrupt-enable bits and a two-bit divider select. When the counter wraps from its maximum value to zero, the block raises an overflow flag. The flag stays set until it is cleared through a dedicated strobe. An interrupt request is driven whenever the flag is set and the overflow enable bit is on. The three other enable bits are not used inside the block and go straight out to neighbouring timer units.

In normal operation, software gets a single chance to pick the divider, and only shortly after reset. A lock state machine has two states, `LK_OPEN` and `LK_SEALED`, and counts cycles from reset release.

- **`LK_OPEN` to `LK_SEALED`:** the machine moves on the first normal-mode register write, or on the 64th cycle (edge 63), whichever comes first.
- **`LK_SEALED` to `LK_SEALED`:** once sealed, the machine stays sealed until the next reset.

While the special-mode input is high, the divider select may be written freely. Such writes do not count as the single normal-mode write.

Top module: `pst_timer`

## Requirements
- R1: While reset is asserted, and right after it, the register reads 0x00, the counter reads 0, and the overflow flag, the interrupt request and all three enable outputs are 0.
- R2: The register layout is: bit 7 overflow interrupt enable, bit 6 periodic interrupt enable, bit 5 accumulator-overflow enable, bit 4 edge enable, bits 3:2 always read 0, bits 1:0 divider select. Bits 7:4 take the write data on every write (`reg_sel` and `reg_we` both high at a clock edge).
- R3: Edge 0 is the first rising clock edge with reset released. In normal mode, a divider-select write is accepted at edges 0 through 63. From edge 64 onward it is ignored.
- R4: In normal mode, only the first accepted divider-select write takes effect. Every later write leaves bits 1:0 unchanged.
- R5: With `special_mode` high, every write loads bits 1:0, at any time. Such writes do not use up the single normal-mode write.
- R6: The divider select picks how often the counter advances: 00 every clock, 01 every 4 clocks, 10 every 8 clocks, 11 every 16 clocks. The prescaler is a free-running 4-bit counter, so over any 16 consecutive edges the counter advances by 16, 4, 2 or 1.
- R7: When the counter advances from 0xFFFF to 0x0000, the overflow flag is set, whatever the enable bits hold. A one-cycle pulse on `ovf_clr` clears it. If a set and a clear fall on the same edge, the set wins.
- R8: `ovf_irq` is high exactly when the overflow flag is set and register bit 7 is 1.
- R9: `rti_en`, `pacc_ovf_en` and `edge_en` follow register bits 6, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Lifts the divider-select write lock while high |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Free-running counter value |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Masked overflow interrupt request |
| rti_en | output | 1 | Periodic interrupt enable to sibling unit |
| pacc_ovf_en | output | 1 | Accumulator overflow enable to sibling unit |
| edge_en | output | 1 | Input edge interrupt enable to sibling unit |

## Verification
The bench probes the window at both of its edges:

- **Last open edge:** a write at edge 63 must land. An off-by-one window would reject it.
- **First closed edge:** a write at edge 64 must be dropped. A window that is one cycle too long would accept it.
- **Second write:** a second normal-mode write must leave the divider alone. A lock that watched only the window would let it through.
- **Special-mode writes:** a special-mode write followed by a normal-mode write must leave the single write still available. A lock that counted special writes would seal too early.

The divider ratios are measured as counter deltas over 16 edges, which exposes a swapped encoding. The wrap test checks three things:

- the flag is set even though the interrupt is disabled, which exposes a gated flag;
- the interrupt rises once the enable bit is written, which exposes a latched interrupt;
- the flag clears on the strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    localparam int BIT_OVF_EN  = 7;
    localparam int BIT_RTI_EN  = 6;
    localparam int BIT_PACC_EN = 5;
    localparam int BIT_EDGE_EN = 4;
    localparam int DIV_W       = 2;
endpackage

// File: rtl/tmr_lock_fsm.sv
module tmr_lock_fsm
    import tmr_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic special_mode,
    input  logic wr_req,
    output logic wr_grant,
    output logic sealed
);
    localparam int CW = $clog2(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    lock_state_e state_q, state_d;
    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  win_cnt <= '0;
        else if (state_q == LK_OPEN) win_cnt <= win_cnt + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if ((wr_req && !special_mode) || win_cnt == LAST)
                    state_d = LK_SEALED;
            end
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    always_comb begin
        wr_grant = 1'b0;
        sealed   = 1'b0;
        unique case (state_q)
            LK_OPEN:   wr_grant = wr_req;
            LK_SEALED: begin
                sealed   = 1'b1;
                wr_grant = wr_req && special_mode;
            end
        endcase
    end

    // R4: once sealed, only a reset reopens the lock
    a_r4_stay_sealed: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LK_SEALED |=> state_q == LK_SEALED);
    // R3: the window closes after its last cycle
    a_r3_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && win_cnt == LAST) |=> state_q == LK_SEALED);
    // R5: a special-mode write does not seal the lock
    a_r5_special_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && special_mode && win_cnt != LAST) |=> state_q == LK_OPEN);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [PSC_W-1:0] psc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc <= '0;
        else        psc <= psc + 1'b1;
    end

    always_comb begin
        unique case (div_sel)
            2'b00: tick = 1'b1;
            2'b01: tick = &psc[1:0];
            2'b10: tick = &psc[2:0];
            2'b11: tick = &psc[3:0];
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    logic wrap;
    assign wrap = tick && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R6: the counter holds between prescaler ticks
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R7: a wrap always raises the flag
    a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag && count == '0));
endmodule

// File: rtl/pst_timer.sv
module pst_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             ovf_irq,
    output logic             rti_en,
    output logic             pacc_ovf_en,
    output logic             edge_en
);
    logic             wr_req, div_grant, sealed, tick;
    logic [3:0]       en_q;
    logic [DIV_W-1:0] div_q;

    assign wr_req = reg_sel && reg_we;

    tmr_lock_fsm #(.WINDOW(WINDOW)) u_lock (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .wr_req(wr_req), .wr_grant(div_grant), .sealed(sealed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            div_q <= '0;
        end else begin
            if (wr_req)    en_q  <= reg_wdata[7:4];
            if (div_grant) div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    tmr_prescaler #(.PSC_W(4)) u_psc (
        .clk(clk), .rst_n(rst_n), .div_sel(div_q), .tick(tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(ovf_clr),
        .count(count), .flag(ovf_flag)
    );

    assign reg_rdata   = {en_q, 2'b00, div_q};
    assign ovf_irq     = ovf_flag && reg_rdata[BIT_OVF_EN];
    assign rti_en      = reg_rdata[BIT_RTI_EN];
    assign pacc_ovf_en = reg_rdata[BIT_PACC_EN];
    assign edge_en     = reg_rdata[BIT_EDGE_EN];

    // R4: a sealed divider in normal mode never changes
    a_r4_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && !special_mode) |=> $stable(div_q));
    // R2: the upper enable bits follow every write
    a_r2_enables_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> en_q == $past(reg_wdata[7:4]));
endmodule

// File: tb/test_pst_timer.sv
module test_pst_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, ovf_irq, rti_en, pacc_ovf_en, edge_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    pst_timer i_pst_timer (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_clr(ovf_clr), .count(count),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .rti_en(rti_en),
        .pacc_ovf_en(pacc_ovf_en), .edge_en(edge_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // after return the next posedge is edge 0
    task automatic do_reset(input logic spec);
        @(negedge clk);
        rst_n = 1'b0;
        special_mode = spec;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // write lands on the next edge; returns at the following negedge
    task automatic wr(input logic [7:0] d);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic t_reset_state();
        special_mode = 1'b1;
        wr(8'hF3);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 rdata in reset", reg_rdata, 8'h00);
        chk("R1 count in reset", count, 0);
        chk("R1 flag/irq in reset", {ovf_flag, ovf_irq}, 0);
        chk("R1 enable outputs in reset", {rti_en, pacc_ovf_en, edge_en}, 0);
    endtask

    task automatic t_write_at_63();
        do_reset(1'b0);
        repeat (63) @(negedge clk);
        wr(8'hFE);
        chk("R3 write at edge 63 taken", reg_rdata, 8'hF2);
        chk("R2 bits 3:2 read zero", reg_rdata[3:2], 0);
        chk("R9 enables out", {rti_en, pacc_ovf_en, edge_en}, 3'b111);
        wr(8'h01);
        chk("R4 second write keeps divider", reg_rdata, 8'h02);
        chk("R9 enables cleared", {rti_en, pacc_ovf_en, edge_en}, 3'b000);
        wr(8'h50);
        chk("R9 mixed enables", {rti_en, pacc_ovf_en, edge_en}, 3'b101);
    endtask

    task automatic t_write_at_64();
        do_reset(1'b0);
        repeat (64) @(negedge clk);
        wr(8'h33);
        chk("R3 write at edge 64 rejected", reg_rdata, 8'h30);
    endtask

    task automatic t_early_once();
        do_reset(1'b0);
        wr(8'h01);
        chk("R3 write at edge 0 taken", reg_rdata, 8'h01);
        repeat (3) @(negedge clk);
        wr(8'h03);
        chk("R4 second write inside window rejected", reg_rdata, 8'h01);
    endtask

    task automatic t_special();
        do_reset(1'b1);
        repeat (100) @(negedge clk);
        wr(8'h03);
        chk("R5 special late write", reg_rdata, 8'h03);
        wr(8'h01);
        chk("R5 special repeat write", reg_rdata, 8'h01);
        special_mode = 1'b0;
        wr(8'h02);
        chk("R3 normal write after window", reg_rdata, 8'h01);
        do_reset(1'b1);
        wr(8'h01);
        special_mode = 1'b0;
        wr(8'h02);
        chk("R5 special write leaves single write", reg_rdata, 8'h02);
    endtask

    task automatic t_ratios();
        do_reset(1'b1);
        for (int s = 0; s < 4; s++) begin
            logic [15:0] c0;
            int exp_d;
            wr(8'(s));
            c0 = count;
            repeat (16) @(negedge clk);
            exp_d = (s == 0) ? 16 : (s == 1) ? 4 : (s == 2) ? 2 : 1;
            chk($sformatf("R6 delta for select %0d", s), 32'(count - c0), exp_d);
        end
    endtask

    task automatic t_overflow();
        int guard = 0;
        do_reset(1'b0);
        @(negedge clk);
        chk("R7 no flag before wrap", ovf_flag, 0);
        while (count != 16'hFFFF && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        chk("R6 reached max", count, 16'hFFFF);
        @(negedge clk);
        chk("R7 wrap to zero", count, 0);
        chk("R7 flag set with enable off", ovf_flag, 1);
        chk("R8 irq masked", ovf_irq, 0);
        wr(8'h80);
        chk("R8 irq after enable", ovf_irq, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R7 flag cleared", ovf_flag, 0);
        chk("R8 irq cleared", ovf_irq, 0);
    endtask

    initial begin
        t_reset_state();
        t_write_at_63();
        t_write_at_64();
        t_early_once();
        t_special();
        t_ratios();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule